// File: doc/BRIEF.md
# Two-Port PS/2 Host Register Front End

This block is the register-level face of a PS/2 host controller that serves two devices, typically a keyboard and a mouse. A processor reaches it over a simple 32-bit word bus. Each port has a data word and a status word. A fixed identification word sits at offset zero. The line-level serialiser is outside the block. Toward each port the block takes a byte stream that carries a frame-error tag and no back-pressure. It drives a byte stream out with a valid/ready handshake.

Each port holds a 4-entry receive queue and a 2-entry transmit queue. Reading a port's data word pops the oldest received byte. Writing the data word queues a byte for sending. Two error flags are sticky: one marks a dropped byte, one marks a byte that arrived with a framing or parity fault. A read of the data word clears both. One registered interrupt line serves both ports. Each port gates its share of that line with its own receive enable and transmit enable.

Top module: `ps2h_top`

## Requirements
- R1: A read of byte offset 0 returns 0x0001F609. Writes to offset 0 have no effect.
- R2: Word offsets are decoded from address bits 5:2, and bits 1:0 are ignored. The data word of port p is at byte offset 4+4p and its status word is at 12+4p, for p in 0..1. A read of any other offset returns 0. A write to any other offset changes no state.
- R3: The status word reads as follows: bit0 frame-error flag, bit1 overflow flag, bit2 receive interrupt enable, bit3 receive byte available, bit4 transmit queue not full, bit5 transmit interrupt enable. Bits 31:6 read 0.
- R4: A data-word read returns the oldest queued received byte in bits 7:0 and removes it. Bits 31:8 read 0. A read while the queue is empty returns 0. The receive-available bit drops once the queue is empty.
- R5: The receive queue holds 4 bytes. A byte that arrives while the queue is full is discarded and sets the overflow flag, unless a data-word read of that port happens in the same cycle. In that case the byte is stored.
- R6: A byte that arrives with its frame-error input high is still queued and sets the frame-error flag. A data-word read clears both flags. A flag-setting event in the same cycle as the read wins.
- R7: A data-word write queues bits 7:0 into a 2-entry transmit queue. A write while the queue is full is discarded, unless the queue sends a byte in that same cycle. tx_valid and tx_data show the head byte, which leaves the queue on a cycle with tx_valid and tx_ready both high.
- R8: A status-word write loads only the two enables, from bits 2 and 5. Writes to bits 0, 1, 3 and 4 are ignored. Both enables are 0 after reset.
- R9: irq is registered. In the cycle after edge k it is high exactly when, before edge k, some port had a byte available with its receive enable set, or had its transmit enable set with its transmit queue not full.
- R10: bus_rdata is registered. It holds the read result in the cycle after a read request and is 0 after any cycle without a read. Reads and pops take effect at the request edge, and status reads show the state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 2 | Per-port received byte strobe |
| rx_data | input | 16 | Per-port received byte, port p in bits 8p+7:8p |
| rx_frame_err | input | 2 | Per-port framing or parity error tag for the arriving byte |
| tx_valid | output | 2 | Per-port transmit byte available |
| tx_data | output | 16 | Per-port transmit byte, port p in bits 8p+7:8p |
| tx_ready | input | 2 | Per-port serialiser accepts the byte |
| irq | output | 1 | Shared registered interrupt |

## Verification
The assertions assume one register access per cycle, with bus_we and bus_addr meaningful only while bus_req is high. They also assume rx_frame_err matters only alongside rx_valid. The stimulus makes at most one access per cycle. It drives every input at the falling edge. It treats rx_valid as a strobe that has no ready, so receive bytes keep arriving while the queues are full, and that is how the overflow path gets exercised. Addresses are drawn across mapped and unmapped words with random low bits. Directed steps first force the full-queue, read-while-full and write-while-full corners.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  localparam int          NPORTS   = 2;
  localparam logic [31:0] ID_WORD  = 32'h0001F609;
  localparam int          ST_FRM   = 0;
  localparam int          ST_OVF   = 1;
  localparam int          ST_RXEN  = 2;
  localparam int          ST_RXAV  = 3;
  localparam int          ST_TXNF  = 4;
  localparam int          ST_TXEN  = 5;
  localparam int          ST_W     = 6;
endpackage

// File: rtl/ps2h_fifo.sv
module ps2h_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);
  localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_pop, do_push;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CMAX);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PLAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PLAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CMAX);

  assert_drain_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt == CW'(1)) |=> empty);

  assert_full_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> full);
endmodule

// File: rtl/ps2h_port.sv
module ps2h_port
  import ps2h_pkg::*;
#(
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_data,
  input  logic            wr_data,
  input  logic            wr_stat,
  input  logic [7:0]      wbyte,
  input  logic            w_rxen,
  input  logic            w_txen,
  input  logic            rx_v,
  input  logic [7:0]      rx_b,
  input  logic            rx_fe,
  input  logic            tx_rdy,
  output logic [7:0]      rd_byte,
  output logic [ST_W-1:0] status,
  output logic            irq_cond,
  output logic            tx_v,
  output logic [7:0]      tx_b
);
  logic       rx_empty, rx_full, tx_empty, tx_full;
  logic [7:0] rx_head;
  logic       frm_q, ovf_q, rxen_q, txen_q;
  logic       ovf_set, frm_set;

  ps2h_fifo #(.W(8), .DEPTH(RX_DEPTH)) rx_q (
    .clk(clk), .rst(rst), .push(rx_v), .din(rx_b), .pop(rd_data),
    .dout(rx_head), .empty(rx_empty), .full(rx_full));

  ps2h_fifo #(.W(8), .DEPTH(TX_DEPTH)) tx_q (
    .clk(clk), .rst(rst), .push(wr_data), .din(wbyte), .pop(tx_rdy),
    .dout(tx_b), .empty(tx_empty), .full(tx_full));

  assign ovf_set = rx_v && rx_full && !rd_data;
  assign frm_set = rx_v && rx_fe;

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_q  <= 1'b0;
      ovf_q  <= 1'b0;
      rxen_q <= 1'b0;
      txen_q <= 1'b0;
    end else begin
      if (frm_set)      frm_q <= 1'b1;
      else if (rd_data) frm_q <= 1'b0;
      if (ovf_set)      ovf_q <= 1'b1;
      else if (rd_data) ovf_q <= 1'b0;
      if (wr_stat) begin
        rxen_q <= w_rxen;
        txen_q <= w_txen;
      end
    end
  end

  assign rd_byte = rx_empty ? 8'h00 : rx_head;
  assign tx_v    = !tx_empty;

  always_comb begin
    status          = '0;
    status[ST_FRM]  = frm_q;
    status[ST_OVF]  = ovf_q;
    status[ST_RXEN] = rxen_q;
    status[ST_RXAV] = !rx_empty;
    status[ST_TXNF] = !tx_full;
    status[ST_TXEN] = txen_q;
  end

  assign irq_cond = (rxen_q && !rx_empty) || (txen_q && !tx_full);

  assert_drop_sets_ovf_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_v && rx_full && !rd_data) |=> ovf_q);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !rx_v) |=> (!ovf_q && !frm_q));

  assert_tx_head_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_v && !tx_rdy) |=> (tx_v && $stable(tx_b)));

  assert_enables_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> ($stable(rxen_q) && $stable(txen_q)));
endmodule

// File: rtl/ps2h_top.sv
module ps2h_top
  import ps2h_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NPORTS-1:0]   rx_valid,
  input  logic [8*NPORTS-1:0] rx_data,
  input  logic [NPORTS-1:0]   rx_frame_err,
  output logic [NPORTS-1:0]   tx_valid,
  output logic [8*NPORTS-1:0] tx_data,
  input  logic [NPORTS-1:0]   tx_ready,
  output logic                irq
);
  localparam int WW = ADDR_W - 2;

  logic [WW-1:0]     word;
  logic              rd_req, wr_req;
  logic [NPORTS-1:0] hit_data, hit_stat, cond;
  logic [7:0]        pbyte [NPORTS];
  logic [ST_W-1:0]   pstat [NPORTS];
  logic [31:0]       rd_mux;
  logic              unused_bits;

  assign word        = bus_addr[ADDR_W-1:2];
  assign rd_req      = bus_req && !bus_we;
  assign wr_req      = bus_req && bus_we;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:8], bus_wdata[4:3], bus_wdata[1:0]};

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign hit_data[p] = (word == WW'(1 + p));
    assign hit_stat[p] = (word == WW'(1 + NPORTS + p));

    ps2h_port #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) port_i (
      .clk(clk), .rst(rst),
      .rd_data(rd_req && hit_data[p]),
      .wr_data(wr_req && hit_data[p]),
      .wr_stat(wr_req && hit_stat[p]),
      .wbyte(bus_wdata[7:0]),
      .w_rxen(bus_wdata[ST_RXEN]),
      .w_txen(bus_wdata[ST_TXEN]),
      .rx_v(rx_valid[p]),
      .rx_b(rx_data[8*p +: 8]),
      .rx_fe(rx_frame_err[p]),
      .tx_rdy(tx_ready[p]),
      .rd_byte(pbyte[p]),
      .status(pstat[p]),
      .irq_cond(cond[p]),
      .tx_v(tx_valid[p]),
      .tx_b(tx_data[8*p +: 8]));
  end

  always_comb begin
    rd_mux = '0;
    if (word == '0) rd_mux = ID_WORD;
    for (int p = 0; p < NPORTS; p++) begin
      if (hit_data[p]) rd_mux = {24'h0, pbyte[p]};
      if (hit_stat[p]) rd_mux = {{(32-ST_W){1'b0}}, pstat[p]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_req ? rd_mux : '0;
      irq       <= |cond;
    end
  end

  assert_id_read_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_req && word == '0) |=> (bus_rdata == ID_WORD));

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (bus_rdata == '0));

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && word > WW'(2 * NPORTS)) |=> (bus_rdata == '0));
endmodule

// File: tb/ps2h_top_tb_top.sv
module ps2h_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  rx_valid = '0, rx_frame_err = '0, tx_ready = '0;
  logic [15:0] rx_data = '0;
  logic [1:0]  tx_valid;
  logic [15:0] tx_data;
  logic        irq;

  int vecs = 0, miss = 0;

  logic [7:0] mrx [2][4];
  int         mrxn [2];
  logic [7:0] mtx [2][2];
  int         mtxn [2];
  logic       mfrm [2], movf [2], mrxen [2], mtxen [2];

  always #2.5 clk = ~clk;

  ps2h_top dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_word(input int p);
    return {26'h0, mtxen[p], (mtxn[p] < 2), (mrxn[p] > 0), mrxen[p], movf[p], mfrm[p]};
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int p = 0; p < 2; p++)
      if ((mrxen[p] && mrxn[p] > 0) || (mtxen[p] && mtxn[p] < 2)) r = 1'b1;
    return r;
  endfunction

  // op: 0 idle, 1 read, 2 write. Called at a falling edge.
  task automatic step(input logic [1:0] rv, input logic [15:0] rb, input logic [1:0] fe,
                      input logic [1:0] tr, input int op, input logic [5:0] addr,
                      input logic [31:0] wd);
    int          w;
    logic [31:0] erd;
    logic        eirq;
    string       tag;
    w = int'(addr[5:2]);
    bus_req = (op != 0); bus_we = (op == 2); bus_addr = addr; bus_wdata = wd;
    rx_valid = rv; rx_data = rb; rx_frame_err = fe; tx_ready = tr;
    eirq = exp_irq();
    erd = 32'h0; tag = "R10 idle rdata";
    if (op == 1) begin
      tag = "R2 unmapped read";
      if (w == 0) begin erd = 32'h0001F609; tag = "R1 id read"; end
      for (int p = 0; p < 2; p++) begin
        if (w == 1 + p) begin erd = (mrxn[p] > 0) ? {24'h0, mrx[p][0]} : 32'h0; tag = "R4 data read"; end
        if (w == 3 + p) begin erd = stat_word(p); tag = "R3 status read"; end
      end
    end
    for (int p = 0; p < 2; p++) begin
      logic pop_rx, ovfset;
      pop_rx = (op == 1) && (w == 1 + p);
      ovfset = 1'b0;
      if (pop_rx && mrxn[p] > 0) begin
        for (int i = 0; i < 3; i++) mrx[p][i] = mrx[p][i+1];
        mrxn[p]--;
      end
      if (rv[p]) begin
        if (mrxn[p] < 4) begin mrx[p][mrxn[p]] = rb[8*p +: 8]; mrxn[p]++; end
        else ovfset = 1'b1;
      end
      mfrm[p] = (pop_rx ? 1'b0 : mfrm[p]) | (rv[p] & fe[p]);
      movf[p] = (pop_rx ? 1'b0 : movf[p]) | ovfset;
      if (mtxn[p] > 0 && tr[p]) begin mtx[p][0] = mtx[p][1]; mtxn[p]--; end
      if (op == 2 && w == 1 + p && mtxn[p] < 2) begin mtx[p][mtxn[p]] = wd[7:0]; mtxn[p]++; end
      if (op == 2 && w == 3 + p) begin mrxen[p] = wd[2]; mtxen[p] = wd[5]; end
    end
    @(negedge clk);
    chk(tag, bus_rdata, erd);
    chk("R9 irq", {31'h0, irq}, {31'h0, eirq});
    for (int p = 0; p < 2; p++) begin
      chk("R7 tx_valid", {31'h0, tx_valid[p]}, {31'h0, (mtxn[p] > 0)});
      if (mtxn[p] > 0) chk("R7 tx_data", {24'h0, tx_data[8*p +: 8]}, {24'h0, mtx[p][0]});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    miss++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    for (int p = 0; p < 2; p++) begin
      mrxn[p] = 0; mtxn[p] = 0; mfrm[p] = 0; movf[p] = 0; mrxen[p] = 0; mtxen[p] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset rdata", bus_rdata, 32'h0);
    chk("R9 reset irq", {31'h0, irq}, 32'h0);
    chk("R7 reset tx_valid", {30'h0, tx_valid}, 32'h0);
    // R1: id readable, write ignored
    step(2'b00, 16'h0, 2'b00, 2'b00, 1, 6'h00, 0);
    step(2'b00, 16'h0, 2'b00, 2'b00, 2, 6'h00, 32'hFFFFFFFF);
    step(2'b00, 16'h0, 2'b00, 2'b00, 1, 6'h03, 0);
    // R3 R8: reset status, then write all ones, only enables stick
    step(2'b00, 16'h0, 2'b00, 2'b00, 1, 6'h0C, 0);
    step(2'b00, 16'h0, 2'b00, 2'b00, 2, 6'h0C, 32'hFFFFFFFF);
    step(2'b00, 16'h0, 2'b00, 2'b00, 1, 6'h0C, 0);
    step(2'b00, 16'h0, 2'b00, 2'b00, 2, 6'h0C, 32'h0000_0004);
    // R5 R6: six bytes to port 0, one with frame error, overflow
    for (int i = 0; i < 6; i++)
      step(2'b01, {8'h0, 8'hA0 + 8'(i)}, (i == 1) ? 2'b01 : 2'b00, 2'b00, 1, 6'h0C, 0);
    // R5: arrival while full together with a read is kept
    step(2'b01, 16'h00C7, 2'b00, 2'b00, 1, 6'h04, 0);
    step(2'b00, 16'h0, 2'b00, 2'b00, 1, 6'h0C, 0);
    // R4: drain past empty
    for (int i = 0; i < 6; i++) step(2'b00, 16'h0, 2'b00, 2'b00, 1, 6'h04, 0);
    step(2'b00, 16'h0, 2'b00, 2'b00, 1, 6'h0C, 0);
    // R7: fill tx of port 1, write while full, then write-while-draining
    step(2'b00, 16'h0, 2'b00, 2'b00, 2, 6'h14, 32'h20);
    for (int i = 0; i < 3; i++) step(2'b00, 16'h0, 2'b00, 2'b00, 2, 6'h08, 32'h51 + i);
    step(2'b00, 16'h0, 2'b00, 2'b00, 1, 6'h10, 0);
    step(2'b00, 16'h0, 2'b00, 2'b10, 2, 6'h08, 32'h77);
    step(2'b00, 16'h0, 2'b00, 2'b10, 0, 6'h00, 0);
    step(2'b00, 16'h0, 2'b00, 2'b10, 0, 6'h00, 0);
    // R2: unmapped write then reads
    step(2'b00, 16'h0, 2'b00, 2'b00, 2, 6'h18, 32'hFF);
    step(2'b00, 16'h0, 2'b00, 2'b00, 1, 6'h3C, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] rv, fe, tr;
      int         op;
      logic [5:0] a;
      rv = {($urandom_range(3) == 0), ($urandom_range(3) == 0)};
      fe = {($urandom_range(7) == 0), ($urandom_range(7) == 0)};
      tr = 2'($urandom_range(3));
      op = $urandom_range(2);
      a  = ($urandom_range(9) == 0) ? 6'($urandom_range(63)) : {1'b0, 3'($urandom_range(4)), 2'($urandom_range(3))};
      step(rv, 16'($urandom), fe, tr, op, a, $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule